// File: doc/BRIEF.md
# Daisy-Chained Serializer Readout Engine

This block is the host side of a serial link to a chain of digital-input serializer slices. A single start pulse opens one chip-select frame. The block clocks out exactly enough bits to read every slice in the chain. Each slice returns one word: an input byte alone in the short mode, or an input byte followed by a status byte in the long mode. The mode and the undervoltage-ignore control are taken at the start pulse and held for the whole frame.

In the long mode, the engine recomputes a 5-bit check code over each slice's input byte and compares it with the code in the top of the status byte. It also decodes the temperature and supply bits of each status byte. The fault pins are sampled at the end of the frame and folded into a per-slice valid flag. The input bytes of all slices are delivered together in one wide vector. Data from a slice whose valid flag is low is still delivered, but it should not be trusted. Healthy slices keep their valid flag high even when another slice in the chain has failed.

All outputs change together on a one-cycle done pulse. Between done pulses they hold their values.

Top module: `serchain_reader`

## Requirements
- R1: A frame read in the short mode (mode16_i low at start) has exactly 8·N_SLICES rising clock edges on spi_sclk_o while spi_cs_n_o is low. A frame read in the long mode (mode16_i high) has exactly 16·N_SLICES.
- R2: spi_sclk_o is low whenever spi_cs_n_o is high. spi_miso_i is sampled on each rising edge of spi_sclk_o, most significant bit first. Each level of spi_sclk_o lasts SCLK_HALF clock cycles.
- R3: Slice 0's word comes first in the frame. Bit k of data_o is bit k mod 8 of the input byte of slice k/8. In the long mode, each slice sends its input byte first and its status byte second.
- R4: In the long mode, crc_err_o[s] is set when status bits [7:3] differ from the CRC of the input byte. The CRC uses generator x^5+x^4+x^2+1, runs MSB first and starts from zero.
- R5: In the long mode, ovtemp_o[s] equals status bit 1, which is active high.
- R6: In the long mode, with ignore off, uv_alarm_o[s] is set when status bit 2 is 0, and uv_warn_o[s] is set when status bit 0 is 0.
- R7: With ignore_uv_i high at start, uv_alarm_o, uv_warn_o and fault_o are all zero for every slice, whatever the status bits and fault pins are.
- R8: In the short mode, crc_err_o, ovtemp_o, uv_alarm_o and uv_warn_o are zero, and the fault pin is the only diagnostic.
- R9: valid_o[s] is low exactly when fault_o, crc_err_o, ovtemp_o or uv_alarm_o of slice s is set. A warning on its own leaves the slice valid.
- R10: fault_o[s] reflects fault_i[s] as sampled in the last cycle of the frame. With SHARED_FAULT set, fault_i[0] applies to every slice.
- R11: busy_o rises in the cycle after an accepted start and falls when chip select rises. done_o pulses for one cycle in the cycle after that. The data and flag outputs change only with done_o. A start pulse while busy_o is high is ignored, and so are the mode and ignore values given with it.
- R12: After reset, spi_cs_n_o is 1; spi_sclk_o, busy_o and done_o are 0; and all data, flag and valid outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one readout frame |
| mode16_i | input | 1 | 1: input and status byte per slice; 0: input byte only |
| ignore_uv_i | input | 1 | Disregard undervoltage bits and fault pins |
| fault_i | input | SHARED_FAULT ? 1 : N_SLICES | Fault pins, active high |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_miso_i | input | 1 | Serial data from the chain |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse: outputs updated |
| data_o | output | 8·N_SLICES | Input bytes of all slices |
| crc_err_o | output | N_SLICES | Check-code mismatch per slice |
| ovtemp_o | output | N_SLICES | Overtemperature per slice |
| uv_alarm_o | output | N_SLICES | Undervoltage alarm per slice |
| uv_warn_o | output | N_SLICES | Undervoltage warning per slice |
| fault_o | output | N_SLICES | Fault pin per slice |
| valid_o | output | N_SLICES | Slice data trustworthy |

## Verification
The assertions assume that each frame runs to its end once it has begun. The bench supports this by issuing a new start only after done_o, apart from deliberate starts during busy_o, which must be ignored.

The assertions also assume that the fault pins carry a settled level when chip select rises. The stimulus sets the pins, the mode and the ignore control before each start pulse and holds them until done_o.

The bench's serial-slave model changes spi_miso_i only on falling edges of spi_sclk_o and on the falling edge of chip select. This keeps the sampled bits away from the edges the engine uses.

// File: rtl/sc_pkg.sv
package sc_pkg;

   typedef enum logic [1:0] {
      SC_IDLE  = 2'd0,
      SC_SHIFT = 2'd1,
      SC_TAIL  = 2'd2
   } sc_state_e;

   typedef struct packed {
      logic crc_err;
      logic ovtemp;
      logic uv_alarm;
      logic uv_warn;
      logic fault;
      logic valid;
   } sc_diag_t;

   // 5-bit check code, generator x^5+x^4+x^2+1, MSB first, zero seed
   function automatic logic [4:0] sc_crc5(input logic [7:0] d);
      logic [4:0] r;
      logic       fb;
      r = '0;
      for (int i = 7; i >= 0; i--) begin
         fb = r[4] ^ d[i];
         r  = {r[3:0], 1'b0} ^ (fb ? 5'b10101 : 5'b00000);
      end
      return r;
   endfunction

endpackage

// File: rtl/sc_spi_rx.sv
module sc_spi_rx
   import sc_pkg::*;
#(
   parameter int N_SLICES  = 3,
   parameter int SCLK_HALF = 2,
   parameter int IDXW      = $clog2(2 * N_SLICES + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            mode16_i,
   output logic            sclk_o,
   output logic            cs_n_o,
   input  logic            miso_i,
   output logic            busy_o,
   output logic            byte_vld_o,
   output logic [7:0]      byte_o,
   output logic [IDXW-1:0] byte_idx_o,
   output logic            frame_end_o
);
   localparam int DIVW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
   localparam logic [DIVW-1:0] DIV_LAST  = DIVW'(SCLK_HALF - 1);
   localparam logic [IDXW-1:0] LAST_LONG = IDXW'(2 * N_SLICES - 1);
   localparam logic [IDXW-1:0] LAST_SHRT = IDXW'(N_SLICES - 1);

   sc_state_e       st_q;
   logic [DIVW-1:0] div_q;
   logic [2:0]      bit_q;
   logic [IDXW-1:0] cnt_q, last_q;
   logic [6:0]      sh_q;

   assign busy_o = (st_q != SC_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= SC_IDLE;
         div_q       <= '0;
         bit_q       <= '0;
         cnt_q       <= '0;
         last_q      <= '0;
         sh_q        <= '0;
         sclk_o      <= 1'b0;
         cs_n_o      <= 1'b1;
         byte_vld_o  <= 1'b0;
         byte_o      <= '0;
         byte_idx_o  <= '0;
         frame_end_o <= 1'b0;
      end else begin
         byte_vld_o  <= 1'b0;
         frame_end_o <= 1'b0;
         unique case (st_q)
            SC_IDLE: if (start_i) begin
               st_q   <= SC_SHIFT;
               cs_n_o <= 1'b0;
               sclk_o <= 1'b0;
               div_q  <= '0;
               bit_q  <= '0;
               cnt_q  <= '0;
               last_q <= mode16_i ? LAST_LONG : LAST_SHRT;
            end
            SC_SHIFT: begin
               if (div_q == DIV_LAST) begin
                  div_q  <= '0;
                  sclk_o <= ~sclk_o;
                  if (!sclk_o) begin
                     sh_q  <= {sh_q[5:0], miso_i};
                     bit_q <= bit_q + 3'd1;
                     if (bit_q == 3'd7) begin
                        byte_vld_o <= 1'b1;
                        byte_o     <= {sh_q, miso_i};
                        byte_idx_o <= cnt_q;
                        cnt_q      <= cnt_q + 1'b1;
                        if (cnt_q == last_q) st_q <= SC_TAIL;
                     end
                  end
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
            SC_TAIL: begin
               if (div_q == DIV_LAST) begin
                  div_q       <= '0;
                  sclk_o      <= 1'b0;
                  cs_n_o      <= 1'b1;
                  st_q        <= SC_IDLE;
                  frame_end_o <= 1'b1;
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
            default: st_q <= SC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sc_slice_diag.sv
module sc_slice_diag
   import sc_pkg::*;
(
   input  logic [7:0] in_byte_i,
   input  logic [7:0] st_byte_i,
   input  logic       mode16_i,
   input  logic       ign_uv_i,
   input  logic       fault_pin_i,
   output sc_diag_t   diag_o
);
   logic code_bad;
   assign code_bad = (st_byte_i[7:3] != sc_crc5(in_byte_i));

   always_comb begin
      diag_o.crc_err  = mode16_i & code_bad;
      diag_o.ovtemp   = mode16_i & st_byte_i[1];
      diag_o.uv_alarm = mode16_i & ~ign_uv_i & ~st_byte_i[2];
      diag_o.uv_warn  = mode16_i & ~ign_uv_i & ~st_byte_i[0];
      diag_o.fault    = ~ign_uv_i & fault_pin_i;
      diag_o.valid    = ~(diag_o.fault | diag_o.crc_err |
                          diag_o.ovtemp | diag_o.uv_alarm);
   end
endmodule

// File: rtl/serchain_reader.sv
module serchain_reader
   import sc_pkg::*;
#(
   parameter int N_SLICES     = 3,
   parameter int SCLK_HALF    = 2,
   parameter bit SHARED_FAULT = 1'b0
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     start_i,
   input  logic                                     mode16_i,
   input  logic                                     ignore_uv_i,
   input  logic [(SHARED_FAULT ? 1 : N_SLICES)-1:0] fault_i,
   output logic                                     spi_sclk_o,
   output logic                                     spi_cs_n_o,
   input  logic                                     spi_miso_i,
   output logic                                     busy_o,
   output logic                                     done_o,
   output logic [8*N_SLICES-1:0]                    data_o,
   output logic [N_SLICES-1:0]                      crc_err_o,
   output logic [N_SLICES-1:0]                      ovtemp_o,
   output logic [N_SLICES-1:0]                      uv_alarm_o,
   output logic [N_SLICES-1:0]                      uv_warn_o,
   output logic [N_SLICES-1:0]                      fault_o,
   output logic [N_SLICES-1:0]                      valid_o
);
   localparam int IDXW = $clog2(2 * N_SLICES + 1);

   if (N_SLICES < 1) begin : g_bad_n
      $error("serchain_reader: N_SLICES must be at least 1");
   end
   if (SCLK_HALF < 1) begin : g_bad_half
      $error("serchain_reader: SCLK_HALF must be at least 1");
   end

   logic            byte_vld, frame_end;
   logic [7:0]      rx_byte;
   logic [IDXW-1:0] rx_idx;
   logic            mode_q, ign_q;

   sc_spi_rx #(.N_SLICES(N_SLICES), .SCLK_HALF(SCLK_HALF), .IDXW(IDXW)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .mode16_i   (mode16_i),
      .sclk_o     (spi_sclk_o),
      .cs_n_o     (spi_cs_n_o),
      .miso_i     (spi_miso_i),
      .busy_o     (busy_o),
      .byte_vld_o (byte_vld),
      .byte_o     (rx_byte),
      .byte_idx_o (rx_idx),
      .frame_end_o(frame_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         ign_q  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= frame_end;
         if (start_i && !busy_o) begin
            mode_q <= mode16_i;
            ign_q  <= ignore_uv_i;
         end
      end
   end

   for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
      logic [7:0] in_q, st_q;
      logic       pin;
      logic       wr_in, wr_st;
      sc_diag_t   dg;

      if (SHARED_FAULT) begin : g_shared
         assign pin = fault_i[0];
      end else begin : g_own
         assign pin = fault_i[s];
      end

      assign wr_in = byte_vld && (mode_q ? (rx_idx == IDXW'(2 * s)) : (rx_idx == IDXW'(s)));
      assign wr_st = byte_vld && mode_q && (rx_idx == IDXW'(2 * s + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_q <= '0;
            st_q <= '0;
         end else begin
            if (wr_in) in_q <= rx_byte;
            if (wr_st) st_q <= rx_byte;
         end
      end

      sc_slice_diag u_diag (
         .in_byte_i  (in_q),
         .st_byte_i  (st_q),
         .mode16_i   (mode_q),
         .ign_uv_i   (ign_q),
         .fault_pin_i(pin),
         .diag_o     (dg)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_o[8*s +: 8] <= '0;
            crc_err_o[s]     <= 1'b0;
            ovtemp_o[s]      <= 1'b0;
            uv_alarm_o[s]    <= 1'b0;
            uv_warn_o[s]     <= 1'b0;
            fault_o[s]       <= 1'b0;
            valid_o[s]       <= 1'b0;
         end else if (frame_end) begin
            data_o[8*s +: 8] <= in_q;
            crc_err_o[s]     <= dg.crc_err;
            ovtemp_o[s]      <= dg.ovtemp;
            uv_alarm_o[s]    <= dg.uv_alarm;
            uv_warn_o[s]     <= dg.uv_warn;
            fault_o[s]       <= dg.fault;
            valid_o[s]       <= dg.valid;
         end
      end
   end
endmodule

// File: rtl/sc_readout_chk.sv
module sc_readout_chk #(
   parameter int N_SLICES = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  spi_sclk_o,
   input logic                  spi_cs_n_o,
   input logic                  busy_o,
   input logic                  done_o,
   input logic [8*N_SLICES-1:0] data_o,
   input logic [N_SLICES-1:0]   crc_err_o,
   input logic [N_SLICES-1:0]   ovtemp_o,
   input logic [N_SLICES-1:0]   uv_alarm_o,
   input logic [N_SLICES-1:0]   fault_o,
   input logic [N_SLICES-1:0]   valid_o
);
   logic sclk_d, cs_d;
   int   rises;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
         rises  <= 0;
      end else begin
         sclk_d <= spi_sclk_o;
         cs_d   <= spi_cs_n_o;
         if (cs_d && !spi_cs_n_o)        rises <= 0;
         else if (spi_sclk_o && !sclk_d) rises <= rises + 1;
      end
   end

   // R1
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n_o) |-> (rises == 8 * N_SLICES || rises == 16 * N_SLICES));

   // R2
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n_o |-> !spi_sclk_o);

   // R11
   busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o == !spi_cs_n_o);

   // R11
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |=> (done_o && !busy_o));

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R11
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(data_o));

   // R9
   valid_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o & (crc_err_o | ovtemp_o | uv_alarm_o | fault_o)) == '0);
endmodule

bind serchain_reader sc_readout_chk #(.N_SLICES(N_SLICES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .spi_sclk_o(spi_sclk_o),
   .spi_cs_n_o(spi_cs_n_o),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .data_o    (data_o),
   .crc_err_o (crc_err_o),
   .ovtemp_o  (ovtemp_o),
   .uv_alarm_o(uv_alarm_o),
   .fault_o   (fault_o),
   .valid_o   (valid_o)
);

// File: tb/sim_serchain_reader.sv
module sim_serchain_reader;
   localparam int N      = 3;
   localparam int HALF   = 2;
   localparam int PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, mode16 = 1'b0, ign = 1'b0, miso = 1'b0;
   logic [N-1:0] fpins = '0;

   wire sclk, csn, busy, done, sclk1, csn1, busy1, done1;
   wire [8*N-1:0] data, data1;
   wire [N-1:0] crc, ot, uva, uvw, flt, val;
   wire [N-1:0] crc1, ot1, uva1, uvw1, flt1, val1;

   always #(PERIOD / 2) clk = ~clk;

   serchain_reader #(.N_SLICES(N), .SCLK_HALF(HALF), .SHARED_FAULT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode16_i(mode16), .ignore_uv_i(ign),
      .fault_i(fpins), .spi_sclk_o(sclk), .spi_cs_n_o(csn), .spi_miso_i(miso),
      .busy_o(busy), .done_o(done), .data_o(data), .crc_err_o(crc), .ovtemp_o(ot),
      .uv_alarm_o(uva), .uv_warn_o(uvw), .fault_o(flt), .valid_o(val));

   serchain_reader #(.N_SLICES(N), .SCLK_HALF(HALF), .SHARED_FAULT(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode16_i(mode16), .ignore_uv_i(ign),
      .fault_i(fpins[0]), .spi_sclk_o(sclk1), .spi_cs_n_o(csn1), .spi_miso_i(miso),
      .busy_o(busy1), .done_o(done1), .data_o(data1), .crc_err_o(crc1), .ovtemp_o(ot1),
      .uv_alarm_o(uva1), .uv_warn_o(uvw1), .fault_o(flt1), .valid_o(val1));

   int compared = 0, mismatched = 0;

   // ---------------- serial slave chain ----------------
   logic bitq[$];
   int   rises = 0;

   always @(negedge csn) begin
      rises = 0;
      if (bitq.size() > 0) miso = bitq.pop_front();
   end
   always @(negedge sclk) if (!csn && bitq.size() > 0) miso = bitq.pop_front();
   always @(posedge sclk) if (!csn) rises++;

   // ---------------- reference model ----------------
   logic [7:0] f_in[N], f_st[N];
   logic       m_mode = 0, m_ign = 0;
   logic [8*N-1:0] e_data = '0, p_data;
   logic [N-1:0] e_crc = '0, e_ot = '0, e_uva = '0, e_uvw = '0, e_flt = '0, e_val = '0;
   logic [N-1:0] e_flt1 = '0, e_val1 = '0;
   logic [N-1:0] p_crc, p_ot, p_uva, p_uvw, p_flt, p_val, p_flt1, p_val1;
   logic e_busy = 0, e_done = 0, pend = 0;
   logic cs_prev = 1, start_prev = 0, mode_prev = 0, ign_prev = 0;

   function automatic logic [4:0] ref_crc(input logic [7:0] d);
      logic [7:0] c = d;
      for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'ha8) : (c << 1);
      return c[7:3];
   endfunction

   function automatic logic [7:0] mk_st(input logic [7:0] d, input bit bad_code,
                                        input bit hot, input bit uv_a, input bit uv_w);
      return {ref_crc(d) ^ (bad_code ? 5'h04 : 5'h00), ~uv_a, hot, ~uv_w};
   endfunction

   task automatic chk(input bit ok, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h t=%0t", what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit accept = start_prev && !e_busy;
         e_done = 1'b0;
         if (pend) begin
            e_data = p_data; e_crc = p_crc; e_ot = p_ot; e_uva = p_uva; e_uvw = p_uvw;
            e_flt = p_flt; e_val = p_val; e_flt1 = p_flt1; e_val1 = p_val1;
            e_done = 1'b1; pend = 1'b0;
         end
         if (!cs_prev && csn) begin
            e_busy = 1'b0;
            pend   = 1'b1;
            // R1 frame length in rising serial clock edges
            chk(rises == (m_mode ? 16 * N : 8 * N), "R1 sclk rises", rises, m_mode ? 16 * N : 8 * N);
            for (int s = 0; s < N; s++) begin
               p_data[8*s +: 8] = f_in[s];
               p_crc[s] = m_mode && (f_st[s][7:3] != ref_crc(f_in[s]));
               p_ot[s]  = m_mode && f_st[s][1];
               p_uva[s] = m_mode && !m_ign && !f_st[s][2];
               p_uvw[s] = m_mode && !m_ign && !f_st[s][0];
               p_flt[s] = !m_ign && fpins[s];
               p_flt1[s] = !m_ign && fpins[0];
               p_val[s]  = !(p_crc[s] | p_ot[s] | p_uva[s] | p_flt[s]);
               p_val1[s] = !(p_crc[s] | p_ot[s] | p_uva[s] | p_flt1[s]);
            end
         end
         if (accept) begin
            e_busy = 1'b1;
            m_mode = mode_prev;
            m_ign  = ign_prev;
         end
      end
      // R12 reset values are the initial expectations; R11 busy/done timing
      chk(busy === e_busy, "R11 busy_o", busy, e_busy);
      chk(done === e_done, "R11 done_o", done, e_done);
      chk(csn === !e_busy, "R12 spi_cs_n_o", csn, !e_busy);
      chk(!(csn && sclk), "R2 sclk idle low", sclk, 0);
      chk(data === e_data, "R3 data_o", data, e_data);
      chk(crc === e_crc, m_mode ? "R4 crc_err_o" : "R8 crc_err_o", crc, e_crc);
      chk(ot === e_ot, m_mode ? "R5 ovtemp_o" : "R8 ovtemp_o", ot, e_ot);
      chk(uva === e_uva, m_ign ? "R7 uv_alarm_o" : "R6 uv_alarm_o", uva, e_uva);
      chk(uvw === e_uvw, m_ign ? "R7 uv_warn_o" : "R6 uv_warn_o", uvw, e_uvw);
      chk(flt === e_flt, m_ign ? "R7 fault_o" : "R10 fault_o", flt, e_flt);
      chk(val === e_val, "R9 valid_o", val, e_val);
      chk(data1 === e_data, "R3 shared data_o", data1, e_data);
      chk(flt1 === e_flt1, "R10 shared fault_o", flt1, e_flt1);
      chk(val1 === e_val1, "R9 shared valid_o", val1, e_val1);
      cs_prev = csn; start_prev = start; mode_prev = mode16; ign_prev = ign;
   end

   // ---------------- stimulus ----------------
   task automatic run_frame(input bit m, input bit ig, input logic [N-1:0] pins);
      int waited = 0;
      bitq.delete();
      for (int s = 0; s < N; s++) begin
         for (int b = 7; b >= 0; b--) bitq.push_back(f_in[s][b]);
         if (m) for (int b = 7; b >= 0; b--) bitq.push_back(f_st[s][b]);
      end
      @(posedge clk); #1;
      mode16 = m; ign = ig; fpins = pins; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      while (!done && waited < 4000) begin @(posedge clk); #1; waited++; end
      if (waited >= 4000) chk(0, "R11 frame timeout", waited, 0);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      #(PERIOD * 150000);
      chk(0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1;
      repeat (3) @(posedge clk);

      // R4 R5 R6 R9: long mode, all slices healthy
      f_in[0] = 8'hA5; f_in[1] = 8'h3C; f_in[2] = 8'h01;
      for (int s = 0; s < N; s++) f_st[s] = mk_st(f_in[s], 0, 0, 0, 0);
      run_frame(1, 0, '0);

      // R4 R5: code error on slice 1, overtemperature on slice 2
      f_in[0] = 8'hFF; f_in[1] = 8'h80; f_in[2] = 8'h7E;
      f_st[0] = mk_st(f_in[0], 0, 0, 0, 0);
      f_st[1] = mk_st(f_in[1], 1, 0, 0, 0);
      f_st[2] = mk_st(f_in[2], 0, 1, 0, 0);
      run_frame(1, 0, '0);

      // R6 R9 R10: alarm on slice 0, warning only on slice 1, fault pin slice 2
      f_in[0] = 8'h12; f_in[1] = 8'h34; f_in[2] = 8'h56;
      f_st[0] = mk_st(f_in[0], 0, 0, 1, 1);
      f_st[1] = mk_st(f_in[1], 0, 0, 0, 1);
      f_st[2] = mk_st(f_in[2], 0, 0, 0, 0);
      run_frame(1, 0, 3'b100);

      // R7: same frame with ignore set
      run_frame(1, 1, 3'b100);

      // R10 shared pin: fault_i[0] high reaches all slices of u1
      run_frame(1, 0, 3'b001);

      // R8: short mode, only fault pins matter
      f_in[0] = 8'h00; f_in[1] = 8'hC3; f_in[2] = 8'h99;
      for (int s = 0; s < N; s++) f_st[s] = 8'h00;
      run_frame(0, 0, 3'b010);

      // R7 R8: short mode with ignore
      run_frame(0, 1, 3'b111);

      // R11: start during busy ignored, with mode and ignore changed
      f_in[0] = 8'h5A; f_in[1] = 8'h0F; f_in[2] = 8'hF0;
      for (int s = 0; s < N; s++) f_st[s] = mk_st(f_in[s], 0, 0, 0, 1);
      fork
         run_frame(1, 0, 3'b000);
         begin
            repeat (40) @(posedge clk); #2;
            mode16 = 0; ign = 1; start = 1'b1;
            @(posedge clk); #2;
            start = 1'b0; mode16 = 1; ign = 0;
         end
      join

      // R3: back-to-back short frames with varied data
      for (int k = 0; k < 3; k++) begin
         for (int s = 0; s < N; s++) f_in[s] = 8'(37 * k + 11 * s + 5);
         run_frame(0, 0, '0);
      end

      repeat (5) @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule